// File: doc/BRIEF.md
# Horizontal Line Crop Unit

The block sits in a streaming pixel path and trims a programmable number of pixels from the left and right edge of every line. Pixels travel on a valid/ready stream with 32-bit words and three markers: start of frame, start of line and end of line. Lines are never removed; every incoming line yields one outgoing line, shortened to the programmed window. A bypass flag lets lines through untouched.

Software programs a bypass bit and two packed 32-bit size words. The block captures all three on the first pixel of each frame and keeps them until the next frame starts, so writes during a frame have no effect on it. While it runs, it compares the marker positions it sees with the programmed line width and line count. Any disagreement sets an error flag that stays set until reset.

Top module: `hcrop_line_trim`

## Requirements
- R1: With the bypass bit set for a frame, every pixel of that frame is forwarded with its data and its three markers unchanged, whatever the trim fields hold.
- R2: Size word A carries (input pixels per line − 1) in bits 31:16 and (lines per frame − 1) in bits 15:0.
- R3: Size word B carries the left trim count L in bits 31:16 and the right field Q in bits 15:0; with input width W, columns L up to W − Q − 2 (counting from 0) are kept and all others are dropped, so Q equals W − (L + kept width) − 1.
- R4: When not bypassed, the output start-of-line marker is on the first kept pixel (column L), the end-of-line marker on the last kept pixel, and the start-of-frame marker on the first kept pixel of the frame's first line.
- R5: No vertical cropping: each input line yields exactly one output line, and no output pixel appears without a matching input pixel.
- R6: The bypass bit and both size words are sampled when the start-of-frame pixel is accepted; changes to them later in the frame do not alter that frame's output.
- R7: A dropped pixel is accepted in the same cycle it is offered, whatever the output ready; a kept pixel is accepted exactly when the output side is ready.
- R8: An end-of-line marker at a column other than W − 1, or a pixel at column W − 1 without one, sets the error output from the next cycle on, and it stays set until reset.
- R9: A start-of-frame pixel arriving before the programmed number of lines has completed, or a pixel that is not a start of frame arriving outside a frame, also sets the error output.
- R10: After reset the error output is low and no output pixel is offered while no input is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bypass | input | 1 | Pass whole frame unchanged |
| cfg_size_a | input | 32 | Input width − 1 (31:16), line count − 1 (15:0) |
| cfg_size_b | input | 32 | Left trim (31:16), right field (15:0) |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Input pixel accepted this cycle |
| in_data | input | 32 | Input pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel offered |
| out_ready | input | 1 | Downstream takes the pixel |
| out_data | output | 32 | Output pixel |
| out_sof | output | 1 | First kept pixel of a frame |
| out_sol | output | 1 | First kept pixel of a line |
| out_eol | output | 1 | Last kept pixel of a line |
| err | output | 1 | Sticky geometry mismatch flag |

## Verification
A wrong column counter shows at once on the output: the kept window shifts, so in the very cycle of the faulty pixel the offered output differs from the expected pixel or its markers move, and a counter that never resets to zero also raises the error flag on the next end of line. A wrong line counter shows at the next frame start as a spurious or missing error, one cycle after that pixel is accepted. A configuration register that follows the live inputs shows as a changed window in the first line after a mid-frame write.

// File: rtl/hcrop_pkg.sv
package hcrop_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef logic [HALF_W-1:0] cnt_t;

  typedef struct packed {
    logic bypass;
    cnt_t w_m1;
    cnt_t lines_m1;
    cnt_t left;
    cnt_t right;
  } crop_cfg_t;

  function automatic crop_cfg_t unpack_cfg(logic byp, logic [WORD_W-1:0] a,
                                           logic [WORD_W-1:0] b);
    crop_cfg_t c;
    c.bypass   = byp;
    c.w_m1     = a[WORD_W-1:HALF_W];
    c.lines_m1 = a[HALF_W-1:0];
    c.left     = b[WORD_W-1:HALF_W];
    c.right    = b[HALF_W-1:0];
    return c;
  endfunction

  // column + right + 1, widened so that no sum wraps
  function automatic logic [HALF_W+1:0] right_reach(crop_cfg_t c, cnt_t col);
    return {2'b00, col} + {2'b00, c.right} + 18'd1;
  endfunction

  function automatic logic in_window(crop_cfg_t c, cnt_t col);
    return (col >= c.left) && (right_reach(c, col) <= {2'b00, c.w_m1});
  endfunction

  function automatic logic is_last_kept(crop_cfg_t c, cnt_t col);
    return right_reach(c, col) == {2'b00, c.w_m1};
  endfunction
endpackage

// File: rtl/hcrop_cfg_hold.sv
module hcrop_cfg_hold
  import hcrop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_offer,
  input  logic      frame_take,
  input  crop_cfg_t cfg_live,
  output crop_cfg_t cfg_held,
  output crop_cfg_t cfg_eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_held <= '0;
    else if (frame_take) cfg_held <= cfg_live;
  end

  assign cfg_eff = frame_offer ? cfg_live : cfg_held;
endmodule

// File: rtl/hcrop_pos_track.sv
module hcrop_pos_track
  import hcrop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      sof,
  input  logic      eol,
  input  crop_cfg_t cfg,
  output cnt_t      col_eff,
  output cnt_t      line_eff,
  output logic      in_frame,
  output logic      geo_fault,
  output logic      err
);
  cnt_t col_q, line_q;
  logic last_line;

  assign col_eff   = sof ? '0 : col_q;
  assign line_eff  = sof ? '0 : line_q;
  assign last_line = (line_eff == cfg.lines_m1);

  assign geo_fault = take && (
      ( eol && (col_eff != cfg.w_m1)) ||
      (!eol && (col_eff == cfg.w_m1)) ||
      ( sof &&  in_frame) ||
      (!sof && !in_frame));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      line_q   <= '0;
      in_frame <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (geo_fault) err <= 1'b1;
      if (take) begin
        if (eol) begin
          col_q <= '0;
          if (last_line) begin
            line_q   <= '0;
            in_frame <= 1'b0;
          end else begin
            line_q   <= line_eff + 1'b1;
            in_frame <= 1'b1;
          end
        end else begin
          col_q    <= col_eff + 1'b1;
          line_q   <= line_eff;
          in_frame <= in_frame | sof;
        end
      end
    end
  end
endmodule

// File: rtl/hcrop_keep_gate.sv
module hcrop_keep_gate
  import hcrop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  crop_cfg_t          cfg,
  input  cnt_t               col,
  input  cnt_t               line,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_sof,
  input  logic               in_sol,
  input  logic               in_eol,
  output logic               in_ready,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_sof,
  output logic               out_sol,
  output logic               out_eol,
  output logic               keep
);
  logic first_kept;

  assign keep       = cfg.bypass || in_window(cfg, col);
  assign first_kept = (col == cfg.left);

  assign out_valid = in_valid && keep;
  assign in_ready  = keep ? out_ready : 1'b1;
  assign out_data  = in_data;

  always_comb begin
    if (cfg.bypass) begin
      out_sof = in_sof;
      out_sol = in_sol;
      out_eol = in_eol;
    end else begin
      out_sol = first_kept;
      out_sof = first_kept && (line == '0);
      out_eol = is_last_kept(cfg, col);
    end
  end
endmodule

// File: rtl/hcrop_line_trim.sv
module hcrop_line_trim
  import hcrop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bypass,
  input  logic [31:0]       cfg_size_a,
  input  logic [31:0]       cfg_size_b,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_sol,
  output logic              out_eol,
  output logic              err
);
  crop_cfg_t cfg_live, cfg_held, cfg_eff;
  cnt_t      col_eff, line_eff;
  logic      frame_offer, take, in_frame, geo_fault, keep_w;

  assign cfg_live    = unpack_cfg(cfg_bypass, cfg_size_a, cfg_size_b);
  assign frame_offer = in_valid && in_sof;
  assign take        = in_valid && in_ready;

  hcrop_cfg_hold i_hold (
    .clk(clk), .rst_n(rst_n),
    .frame_offer(frame_offer), .frame_take(take && in_sof),
    .cfg_live(cfg_live), .cfg_held(cfg_held), .cfg_eff(cfg_eff)
  );

  hcrop_pos_track i_pos (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof), .eol(in_eol),
    .cfg(cfg_eff), .col_eff(col_eff), .line_eff(line_eff),
    .in_frame(in_frame), .geo_fault(geo_fault), .err(err)
  );

  hcrop_keep_gate #(.DATA_W(DATA_W)) i_gate (
    .cfg(cfg_eff), .col(col_eff), .line(line_eff),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_sol(in_sol), .in_eol(in_eol), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_sol(out_sol), .out_eol(out_eol), .keep(keep_w)
  );
endmodule

// File: rtl/hcrop_line_trim_chk.sv
module hcrop_line_trim_chk
  import hcrop_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      in_valid,
  input logic      in_ready,
  input logic      in_sof,
  input logic      in_eol,
  input logic      out_valid,
  input logic      out_ready,
  input logic      out_eol,
  input logic      err,
  input logic      take,
  input logic      geo_fault,
  input crop_cfg_t cfg_eff,
  input crop_cfg_t cfg_held
);
  assert_drop_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_valid) |-> in_ready);

  assert_kept_follows_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready == out_ready));

  assert_no_phantom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  assert_bypass_eol_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_eff.bypass && in_eol) |-> (out_valid && out_eol));

  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && in_sof) |=> $stable(cfg_held));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_fault_raises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    geo_fault |=> err);

  always @(posedge clk)
    if (!rst_n) assert_reset_clear_R10: assert (!err);
endmodule

bind hcrop_line_trim hcrop_line_trim_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid),
  .out_ready(out_ready), .out_eol(out_eol), .err(err), .take(take),
  .geo_fault(geo_fault), .cfg_eff(cfg_eff), .cfg_held(cfg_held)
);

// File: tb/test_hcrop_line_trim.sv
module test_hcrop_line_trim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bypass = 1'b0;
  logic [31:0] cfg_size_a = '0, cfg_size_b = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_sof, out_sol, out_eol, err;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int checks = 0, fails = 0;
  int lines_in = 0, lines_out = 0;
  bit chk_on = 1'b1;
  logic [34:0] expq[$];

  always #5 clk = ~clk;

  hcrop_line_trim i_hcrop_line_trim (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass),
    .cfg_size_a(cfg_size_a), .cfg_size_b(cfg_size_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_sol(in_sol), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_sol(out_sol), .out_eol(out_eol), .err(err)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench view of the window: kept when L <= c < L + kept width
  function automatic bit kept_col(int c, int left, int wout);
    return (c >= left) && (c < left + wout);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(!err && !out_valid, "R10 reset state", {err, out_valid}, 0);
    rst_n = 1'b1;
  endtask

  task automatic send_pix(input logic [31:0] d, input bit s, input bit sl,
                          input bit e, input bit exp_keep);
    bit done = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_sol = sl; in_eol = e;
    while (!done) begin
      out_ready = chk_on ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (chk_on) begin
        check(out_valid == exp_keep, "R3 keep decision", out_valid, exp_keep);
        if (!exp_keep)
          check(in_ready, "R7 dropped pixel not stalled", in_ready, 1);
        else
          check(in_ready == out_ready, "R7 kept pixel waits", in_ready, out_ready);
        if (out_valid && out_ready) begin
          if (expq.size() == 0) begin
            check(0, "R5 unexpected output", out_data, 0);
          end else begin
            logic [34:0] e_w;
            e_w = expq.pop_front();
            check({out_sof, out_sol, out_eol, out_data} == e_w,
                  "R4 output pixel and markers",
                  {out_sof, out_sol, out_eol, out_data}, e_w);
            if (out_eol) lines_out++;
          end
        end
      end
      if (in_ready) done = 1'b1;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if ($urandom % 3 == 0) @(negedge clk);
  endtask

  task automatic send_frame(input bit byp, input int w, input int h,
                            input int left, input int wout, input bit scramble);
    int q = w - (left + wout) - 1;
    @(negedge clk);
    cfg_bypass = byp;
    cfg_size_a = {16'(w - 1), 16'(h - 1)};   // R2 packing
    cfg_size_b = {16'(left), 16'(q)};        // R3 packing
    for (int ln = 0; ln < h; ln++) begin
      for (int c = 0; c < w; c++) begin
        logic [31:0] d = $urandom;
        bit k = byp || kept_col(c, left, wout);
        bit es, esl, ee;
        if (byp) begin
          esl = (c == 0); ee = (c == w - 1); es = esl && (ln == 0);
        end else begin
          esl = (c == left); ee = (c == left + wout - 1); es = esl && (ln == 0);
        end
        if (k) expq.push_back({es, esl, ee, d});
        if (c == w - 1) lines_in++;
        send_pix(d, (ln == 0 && c == 0), (c == 0), (c == w - 1), k);
        if (scramble && ln == 0 && c == 0) begin  // R6 mid-frame write
          cfg_bypass = ~byp;
          cfg_size_a = $urandom;
          cfg_size_b = $urandom;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // directed corners
    send_frame(1'b0, 8, 2, 0, 7, 1'b0);   // R3 right field 0 drops one pixel
    send_frame(1'b0, 8, 1, 6, 1, 1'b0);   // single kept pixel
    send_frame(1'b1, 6, 2, 3, 1, 1'b0);   // R1 bypass ignores trims
    send_frame(1'b0, 9, 3, 2, 4, 1'b1);   // R6 config frozen in frame
    send_frame(1'b1, 5, 2, 1, 2, 1'b1);   // R1 + R6
    // constrained random frames
    for (int f = 0; f < 30; f++) begin
      int w = 4 + $urandom % 9;
      int left = $urandom % (w - 1);
      int wout = 1 + $urandom % (w - left - 1);
      send_frame(($urandom % 5 == 0), w, 1 + $urandom % 3, left, wout,
                 ($urandom % 2 == 0));
    end
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R5 all kept pixels delivered", expq.size(), 0);
    check(lines_out == lines_in, "R5 one output line per input line",
          lines_out, lines_in);
    check(err == 1'b0, "R8 no error on well-formed frames", err, 0);

    // R8: line shorter than programmed width
    chk_on = 1'b0;
    do_reset();
    cfg_bypass = 1'b0; cfg_size_a = {16'd7, 16'd0}; cfg_size_b = {16'd1, 16'd1};
    for (int c = 0; c < 6; c++) send_pix(c, c == 0, c == 0, c == 5, 1'b0);
    @(negedge clk);
    check(err == 1'b1, "R8 short line flagged", err, 1);
    repeat (3) @(negedge clk);
    check(err == 1'b1, "R8 flag stays set", err, 1);

    // R8: missing end of line at last column
    do_reset();
    for (int c = 0; c < 8; c++) send_pix(c, c == 0, c == 0, 1'b0, 1'b0);
    @(negedge clk);
    check(err == 1'b1, "R8 long line flagged", err, 1);

    // R9: new frame before the programmed line count completes
    do_reset();
    cfg_size_a = {16'd3, 16'd2};
    for (int c = 0; c < 4; c++) send_pix(c, c == 0, c == 0, c == 3, 1'b0);
    @(negedge clk);
    check(err == 1'b0, "R9 no error mid frame", err, 0);
    send_pix(32'h55, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check(err == 1'b1, "R9 early frame start flagged", err, 1);

    // R9: pixel outside any frame
    do_reset();
    cfg_size_a = {16'd3, 16'd0};
    send_pix(32'h1, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check(err == 1'b1, "R9 pixel outside frame flagged", err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule